// File: doc/BRIEF.md
# Multi-Port Link Sleep Entry Sequencer

This block brings the links of several downstream ports into the ready-for-power-off condition before the system enters a sleep state. Software starts the transition with a write to a power-management control register. The controller sees that write as a rising edge on a sleep request level. It then waits until the completion of that write has been returned to the processor. Only after that does it tell every port, in the same cycle, to transmit its turn-off message. No input reports the link's prior low-power state, so the message goes out whether or not a link was already in L1.

After the strobe, the block follows each port on its own. For each port it waits for the attached device's turn-off acknowledge, and after that for the device's request to enter the L2/L3-ready state. Once every port has finished that exchange, the block raises a proceed level to the system power logic. Proceed stays high until the sleep request is withdrawn or reset is applied. The port count is a parameter and defaults to two.

Top module: `lnk_sleep_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy`, `proceed` and every bit of `turnoff_send` are 0.
- R2: A 0-to-1 change of `sleep_req` while idle starts a sequence, and `busy` reads 1 from the next cycle.
- R3: No turn-off strobe is issued before `cpl_done` has been seen high during a sequence. A `cpl_done` pulse while idle has no effect.
- R4: The first `cpl_done` of a sequence sets every bit of `turnoff_send` to 1 for exactly one cycle, starting on the next cycle. Later `cpl_done` pulses in the same sequence produce no strobe.
- R5: A port counts as ready only after an L23 request (`port_l23` bit high) arrives in a cycle strictly later than its acknowledge (`port_ack` bit high). An L23 request that comes before the acknowledge, or in the same cycle as it, is ignored.
- R6: `proceed` rises only when all ports are ready. It reads 1 two cycles after the cycle in which the last L23 request was driven.
- R7: `proceed` stays at 1 while `sleep_req` stays high. One cycle after `sleep_req` goes low, `proceed` and `busy` both read 0.
- R8: A sleep request edge during a busy sequence is ignored. It causes no new strobe and does not clear the progress already recorded.
- R9: Per-port progress is cleared when a sequence starts. An acknowledge or L23 request that arrives before the turn-off strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request level; its rising edge starts a sequence |
| cpl_done | input | 1 | Pulse: completion of the control write has returned to the processor |
| port_ack | input | NUM_PORTS | Per-port turn-off acknowledge pulse |
| port_l23 | input | NUM_PORTS | Per-port request to enter the L2/L3-ready state |
| turnoff_send | output | NUM_PORTS | Per-port one-cycle strobe: transmit turn-off message |
| busy | output | 1 | A sequence is in progress |
| proceed | output | 1 | All links are ready; sleep entry may continue |

## Verification
The assertions check these properties on every cycle. The strobe lasts one cycle, it reaches all ports together, and it never appears while the block is idle. A port's ready flag is never set unless its acknowledge was recorded first. Proceed rises only when all ready flags are set, and it falls only after the request has dropped. The bench scenarios cover what needs a history of stimulus: the ignored early or same-cycle L23 requests, clearing of stale progress from an earlier sequence, a request edge that arrives mid-sequence, and the exact cycle at which proceed rises.

// File: rtl/lnk_sleep_pkg.sv
package lnk_sleep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAITCPL = 3'd1,
    ST_WAITRDY = 3'd2,
    ST_DONE    = 3'd3
  } seq_state_t;

endpackage

// File: rtl/lnk_port_track.sv
// Per-port progress: acknowledge first, then an L2/L3-ready request.
module lnk_port_track (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  input  logic ack_i,
  input  logic l23_i,
  output logic ack_seen_o,
  output logic ready_o
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ack_seen_o <= 1'b0;
      ready_o    <= 1'b0;
    end else if (arm) begin
      if (ack_i) ack_seen_o <= 1'b1;
      // the request only counts when the ack was recorded in an earlier cycle
      if (l23_i && ack_seen_o) ready_o <= 1'b1;
    end
  end

endmodule

// File: rtl/lnk_seq_fsm.sv
// Sequence control: start edge, wait for completion, strobe, wait for all ready.
module lnk_seq_fsm
  import lnk_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic cpl_done,
  input  logic all_ready,
  output logic start_o,
  output logic arm_o,
  output logic send_o,
  output logic busy_o,
  output logic proceed_o
);

  seq_state_t state, state_nx;
  logic       req_q;

  assign start_o = (state == ST_IDLE) && req && !req_q;
  assign arm_o   = (state == ST_WAITRDY);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (start_o)   state_nx = ST_WAITCPL;
      ST_WAITCPL: if (cpl_done)  state_nx = ST_WAITRDY;
      ST_WAITRDY: if (all_ready) state_nx = ST_DONE;
      ST_DONE:    if (!req)      state_nx = ST_IDLE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_q     <= 1'b0;
      send_o    <= 1'b0;
      busy_o    <= 1'b0;
      proceed_o <= 1'b0;
    end else begin
      state     <= state_nx;
      req_q     <= req;
      send_o    <= (state == ST_WAITCPL) && cpl_done;
      busy_o    <= (state_nx != ST_IDLE);
      proceed_o <= (state_nx == ST_DONE);
    end
  end

endmodule

// File: rtl/lnk_sleep_seq.sv
module lnk_sleep_seq #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sleep_req,
  input  logic                 cpl_done,
  input  logic [NUM_PORTS-1:0] port_ack,
  input  logic [NUM_PORTS-1:0] port_l23,
  output logic [NUM_PORTS-1:0] turnoff_send,
  output logic                 busy,
  output logic                 proceed
);

  logic                 seq_start;
  logic                 seq_arm;
  logic                 send_one;
  logic [NUM_PORTS-1:0] ack_vec;
  logic [NUM_PORTS-1:0] ready_vec;

  lnk_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (sleep_req),
    .cpl_done  (cpl_done),
    .all_ready (&ready_vec),
    .start_o   (seq_start),
    .arm_o     (seq_arm),
    .send_o    (send_one),
    .busy_o    (busy),
    .proceed_o (proceed)
  );

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
    lnk_port_track u_trk (
      .clk        (clk),
      .rst        (rst),
      .clr        (seq_start),
      .arm        (seq_arm),
      .ack_i      (port_ack[gi]),
      .l23_i      (port_l23[gi]),
      .ack_seen_o (ack_vec[gi]),
      .ready_o    (ready_vec[gi])
    );
    assign turnoff_send[gi] = send_one;
  end

endmodule

// File: rtl/lnk_sleep_seq_chk.sv
module lnk_sleep_seq_chk #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sleep_req,
  input logic [NUM_PORTS-1:0] turnoff_send,
  input logic                 busy,
  input logic                 proceed,
  input logic [NUM_PORTS-1:0] ack_vec,
  input logic [NUM_PORTS-1:0] ready_vec
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!busy && !proceed && turnoff_send == '0));

  p_strobe_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (turnoff_send != '0) |-> busy);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    (turnoff_send != '0) |=> (turnoff_send == '0));

  p_strobe_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    (turnoff_send == '0) || (&turnoff_send));

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_rdy
    p_ready_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_vec[gi]) |-> $past(ack_vec[gi]));
  end

  p_proceed_all_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(proceed) |-> (&$past(ready_vec)));

  p_proceed_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(proceed) |-> !$past(sleep_req));

  p_proceed_busy_r7: assert property (@(posedge clk) disable iff (rst)
    proceed |-> busy);

endmodule

bind lnk_sleep_seq lnk_sleep_seq_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_req    (sleep_req),
  .turnoff_send (turnoff_send),
  .busy         (busy),
  .proceed      (proceed),
  .ack_vec      (ack_vec),
  .ready_vec    (ready_vec)
);

// File: tb/lnk_sleep_seq_tb.sv
module lnk_sleep_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_req = 1'b0;
  logic          cpl_done = 1'b0;
  logic [NP-1:0] port_ack = '0;
  logic [NP-1:0] port_l23 = '0;
  logic [NP-1:0] turnoff_send;
  logic          busy;
  logic          proceed;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_sleep_seq #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .cpl_done(cpl_done),
    .port_ack(port_ack), .port_l23(port_l23),
    .turnoff_send(turnoff_send), .busy(busy), .proceed(proceed)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_cpl();
    cpl_done = 1'b1; step(); cpl_done = 1'b0;
  endtask

  task automatic pulse_ack(input logic [NP-1:0] v);
    port_ack = v; step(); port_ack = '0;
  endtask

  task automatic pulse_l23(input logic [NP-1:0] v);
    port_l23 = v; step(); port_l23 = '0;
  endtask

  task automatic drop_req();
    sleep_req = 1'b0; step();
    chk("R7 proceed low after drop", proceed, 0);
    chk("R7 busy low after drop", busy, 0);
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 busy in reset", busy, 0);
    chk("R1 proceed in reset", proceed, 0);
    rst = 1'b0; step();
    chk("R1 strobe after reset", turnoff_send, 0);
    chk("R1 busy after reset", busy, 0);
  endtask

  task automatic t_idle_cpl();
    cpl_done = 1'b1; step();
    chk("R3 no strobe on idle cpl", turnoff_send, 0);
    cpl_done = 1'b0; step();
    chk("R3 idle stays idle", busy, 0);
  endtask

  task automatic t_basic();
    sleep_req = 1'b1; step();
    chk("R2 busy after start", busy, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 no strobe before cpl", turnoff_send, 0);
    end
    pulse_cpl();
    chk("R4 strobe all ports", turnoff_send, ALL);
    step();
    chk("R4 strobe one cycle", turnoff_send, 0);
    pulse_cpl();
    chk("R4 no second strobe", turnoff_send, 0);
    pulse_ack(2'b01);
    pulse_ack(2'b10);
    pulse_l23(2'b01);
    step();
    chk("R6 no proceed with one port ready", proceed, 0);
    port_l23 = 2'b10; step(); port_l23 = '0;
    chk("R6 proceed not yet", proceed, 0);
    step();
    chk("R6 proceed after all ready", proceed, 1);
    step(5);
    chk("R7 proceed held", proceed, 1);
    chk("R7 busy held", busy, 1);
    drop_req();
  endtask

  task automatic t_order();
    sleep_req = 1'b1; step();
    pulse_cpl(); step();
    pulse_l23(ALL);
    step(2);
    chk("R5 l23 before ack ignored", proceed, 0);
    port_ack = ALL; port_l23 = ALL; step();
    port_ack = '0; port_l23 = '0; step(3);
    chk("R5 same-cycle l23 ignored", proceed, 0);
    pulse_l23(ALL); step();
    chk("R5 l23 after ack counts", proceed, 1);
    drop_req();
  endtask

  task automatic t_clear();
    sleep_req = 1'b1; step();
    pulse_ack(ALL); pulse_l23(ALL);
    pulse_cpl(); step();
    step(2);
    chk("R9 pre-strobe events ignored", proceed, 0);
    pulse_ack(ALL); pulse_l23(ALL); step();
    chk("R9 proceed after real exchange", proceed, 1);
    drop_req();
    sleep_req = 1'b1; step();
    pulse_cpl(); step();
    pulse_l23(ALL); step(3);
    chk("R9 progress cleared at start", proceed, 0);
    pulse_ack(ALL); pulse_l23(ALL); step();
    chk("R9 second sequence completes", proceed, 1);
    drop_req();
  endtask

  task automatic t_busy_ignore();
    sleep_req = 1'b1; step();
    pulse_cpl(); step();
    pulse_ack(ALL);
    sleep_req = 1'b0; step();
    sleep_req = 1'b1; step();
    chk("R8 still busy", busy, 1);
    chk("R8 no new strobe", turnoff_send, 0);
    pulse_cpl();
    chk("R8 no strobe on cpl", turnoff_send, 0);
    pulse_l23(ALL); step();
    chk("R8 progress kept", proceed, 1);
    drop_req();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_cpl();
    t_basic();
    t_order();
    t_clear();
    t_busy_ignore();
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule